// File: doc/BRIEF.md
# 16-QAM Mapper and Guard-Band Framer

This block turns a stream of encoded bits, delivered four at a time, into frequency-domain samples for a 128-point inverse FFT. Each four-bit group becomes one 16-QAM constellation point with signed in-phase (I) and quadrature (Q) components.

The block gathers 64 such points to form one OFDM symbol. It then emits a 128-sample vector. The vector starts with 32 zero samples, follows with the 64 data points in the order they arrived, and ends with 32 more zero samples. Every sample, zero or data, takes one output beat. Each beat carries its position in the vector, and a marker flags position 0.

Both sides use valid/ready handshakes. The block has one symbol buffer. It accepts input while it fills that buffer, and it emits output only after the buffer is full. It refuses new input until the last of the 128 samples has been taken.

Top module: `qam_framer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each nibble maps to I from bits [3:2] and to Q from bits [1:0]. A pair maps to a 4-bit two's-complement level as follows: 00 gives +3, 01 gives +1, 11 gives -1, and 10 gives -3. The first bit of a pair is its sign, and adjacent levels differ in one bit.
- R3: Samples at positions 0 to 31 and 96 to 127 have I = 0 and Q = 0.
- R4: Positions 32 to 95 carry the 64 accepted nibbles, mapped in the order they arrived: the k-th nibble appears at position 32+k.
- R5: `out_idx` runs from 0 to 127, rising by one on each accepted output beat. `out_sos` is high exactly on the beat with index 0.
- R6: No output is offered until all 64 nibbles of a symbol are accepted. A partial symbol is held indefinitely while `in_valid` is low.
- R7: While a symbol is streaming out, `in_ready` is 0. Input presented during that time is ignored and does not alter the stored symbol.
- R8: When `out_valid` is high and `out_ready` is low, the index and the I/Q values are held unchanged on the next cycle.
- R9: In the cycle after the beat with index 127 is accepted, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input nibble valid |
| in_ready | output | 1 | Block can accept a nibble |
| in_bits | input | 4 | Encoded bits; [3:2] select I, [1:0] select Q |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_i | output | 4 | Signed in-phase level |
| out_q | output | 4 | Signed quadrature level |
| out_idx | output | 7 | Sample position in the 128-entry vector |
| out_sos | output | 1 | Start-of-symbol marker, high at index 0 |

## Verification
A wrong fill count shifts every data sample by one or more positions, or makes output start before the 64th nibble arrives. Either fault shows on the first data beat, at index 32, or on the rise of `out_valid`. A slipped read counter shows as a nonzero guard sample, a skipped index or a misplaced start marker within the same symbol. A buffer written while the block is sending corrupts the next symbol's data beats. Symbols are checked under several backpressure rhythms so that a counter advancing during a stall shows at once as a repeated or skipped index.

// File: rtl/qam_framer.sv
module qam_framer #(
  parameter int N_DATA  = 64,
  parameter int N_GUARD = 32,
  localparam int N_FFT = N_DATA + 2 * N_GUARD,
  localparam int IDX_W = $clog2(N_FFT),
  localparam int DW    = $clog2(N_DATA)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [3:0]              in_bits,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [3:0]       out_i,
  output logic signed [3:0]       out_q,
  output logic [IDX_W-1:0]        out_idx,
  output logic                    out_sos
);

  localparam logic [DW-1:0]    WR_LAST = DW'(N_DATA - 1);
  localparam logic [IDX_W-1:0] RD_LAST = IDX_W'(N_FFT - 1);
  localparam logic [IDX_W-1:0] DATA_LO = IDX_W'(N_GUARD);
  localparam logic [IDX_W-1:0] DATA_HI = IDX_W'(N_GUARD + N_DATA);

  logic [3:0]       store [N_DATA];
  logic             sending;
  logic [DW-1:0]    wr_cnt;
  logic [IDX_W-1:0] rd_cnt;
  logic [DW-1:0]    rd_addr;
  logic [3:0]       nib;
  logic             in_data;

  function automatic logic signed [3:0] level(input logic [1:0] p);
    case (p)
      2'b00:   level = 4'sd3;
      2'b01:   level = 4'sd1;
      2'b11:   level = -4'sd1;
      default: level = -4'sd3;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending <= 1'b0;
      wr_cnt  <= '0;
      rd_cnt  <= '0;
    end else if (!sending) begin
      if (in_valid) begin
        wr_cnt <= (wr_cnt == WR_LAST) ? '0 : wr_cnt + 1'b1;
        if (wr_cnt == WR_LAST) sending <= 1'b1;
      end
    end else if (out_ready) begin
      rd_cnt <= (rd_cnt == RD_LAST) ? '0 : rd_cnt + 1'b1;
      if (rd_cnt == RD_LAST) sending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!sending && in_valid) store[wr_cnt] <= in_bits;
  end

  assign rd_addr   = DW'(rd_cnt - DATA_LO);
  assign nib       = store[rd_addr];
  assign in_data   = (rd_cnt >= DATA_LO) && (rd_cnt < DATA_HI);

  assign in_ready  = !sending;
  assign out_valid = sending;
  assign out_idx   = rd_cnt;
  assign out_sos   = sending && (rd_cnt == '0);
  assign out_i     = in_data ? level(nib[3:2]) : 4'sd0;
  assign out_q     = in_data ? level(nib[1:0]) : 4'sd0;

endmodule

// File: rtl/qam_framer_chk.sv
module qam_framer_chk #(
  parameter int N_DATA  = 64,
  parameter int N_GUARD = 32,
  localparam int N_FFT = N_DATA + 2 * N_GUARD,
  localparam int IDX_W = $clog2(N_FFT)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [3:0]       out_i,
  input logic signed [3:0]       out_q,
  input logic [IDX_W-1:0]        out_idx,
  input logic                    out_sos
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FFT - 1);
  localparam logic [IDX_W-1:0] LO   = IDX_W'(N_GUARD);
  localparam logic [IDX_W-1:0] HI   = IDX_W'(N_GUARD + N_DATA);

  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_idx != LAST |=> out_valid && out_idx == $past(out_idx) + 1'b1);

  a_r5_sos_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sos && out_idx == '0);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_i) && $stable(out_q));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_idx == LAST |=> in_ready && !out_valid);

  a_r6_full_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r7_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r3_guard_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_idx < LO || out_idx >= HI) |-> out_i == 4'sd0 && out_q == 4'sd0);

  a_r2_odd_levels: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_idx >= LO && out_idx < HI |-> out_i[0] && out_q[0]);

endmodule

bind qam_framer qam_framer_chk #(.N_DATA(N_DATA), .N_GUARD(N_GUARD)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
  .out_idx(out_idx), .out_sos(out_sos)
);

// File: tb/qam_framer_test.sv
module qam_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_bits = 4'h0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [3:0] out_i, out_q;
  logic [6:0] out_idx;
  logic out_sos;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // {nibble, expected I, expected Q} per R2
  localparam logic [11:0] VEC [16] = '{
    12'h033, 12'h131, 12'h23D, 12'h33F,
    12'h413, 12'h511, 12'h61D, 12'h71F,
    12'h8D3, 12'h9D1, 12'hADD, 12'hBDF,
    12'hCF3, 12'hDF1, 12'hEFD, 12'hFFF
  };

  always #10 clk = ~clk;

  qam_framer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .out_idx(out_idx), .out_sos(out_sos)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int entry(input int s, input int k);
    return (k * 7 + s) % 16;
  endfunction

  task automatic push(input logic [3:0] n, input int gap);
    repeat (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_bits  = n;
    @(posedge clk);
  endtask

  task automatic fill(input int s, input int from, input int upto, input int gap);
    for (int k = from; k < upto; k++) push(VEC[entry(s, k)][11:8], gap);
  endtask

  task automatic recv(input int s, input int stall_mod);
    int e = 0;
    int cyc = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_bits  = 4'hF;
    while (e < 128) begin
      bit rdy;
      logic signed [3:0] ei, eq;
      rdy = (stall_mod == 0) || ((cyc % stall_mod) != 0);
      cyc++;
      if (e < 32 || e >= 96) begin
        ei = 4'sd0; eq = 4'sd0;
      end else begin
        ei = VEC[entry(s, e - 32)][7:4];
        eq = VEC[entry(s, e - 32)][3:0];
      end
      chk(out_valid == 1'b1, "R6 out_valid during symbol", int'(out_valid), 1);
      chk(in_ready == 1'b0, "R7 in_ready while sending", int'(in_ready), 0);
      chk(int'(out_idx) == e, "R5/R8 index", int'(out_idx), e);
      chk(out_sos == (e == 0), "R5 sos", int'(out_sos), int'(e == 0));
      if (e < 32 || e >= 96) begin
        chk(out_i == ei && out_q == eq, "R3 guard zero", int'(out_i) * 16 + int'(out_q), 0);
      end else begin
        chk(out_i == ei, "R2/R4 I level", int'(out_i), int'(ei));
        chk(out_q == eq, "R2/R4 Q level", int'(out_q), int'(eq));
      end
      out_ready = rdy;
      if (rdy) begin
        if (e == 127) in_valid = 1'b0;
        e++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 release after last beat",
        int'({in_ready, out_valid}), 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    fill(0, 0, 40, 0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 partial symbol held", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R6 still accepting", int'(in_ready), 1);
    end
    fill(0, 40, 64, 0);
    recv(0, 0);

    for (int s = 1; s < 4; s++) begin
      fill(s, 0, 64, s - 1);
      recv(s, (s == 1) ? 0 : s);
    end

    fill(9, 0, 64, 0);
    recv(9, 5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule